// File: doc/BRIEF.md
# Associative Region Area Accumulator

This block measures the size of every labeled region held in one row of a two-plane associative memory. Each memory position pairs a label word (plane B) with a count word (plane A). Before a run, plane B is loaded with region labels and plane A is cleared to zero. The block itself holds no pixel storage. It drives the memory's command port and reads back the word pair it asks for.

On a start request the block walks the positions from address 0 upward. Each position takes three cycles. In the first cycle it issues a read of the position's label and count. In the second it registers the label and the count plus one, with the count held at the largest value the word can carry. In the third it issues an associative broadcast: the memory matches the label against every plane-B word and writes the new count into the plane-A word of every match. Label value zero marks background. No broadcast is issued for it, so its count stays zero.

Because every position of a region receives each increment at once, the plane-A word of each position ends up holding the full area of its region. The block needs no table with one counter per label. A one-cycle done pulse marks the end of the scan.

Top module: `region_area_acc`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `cmdOp` is the no-operation code 0 until a scan starts.
- R2: A `start` sampled high while idle begins a scan. Read commands (`cmdOp` = 1) are issued for addresses 0, 1, …, N-1 in ascending order, exactly once each.
- R3: The incremented count saturates at 2^CW-1. A region with more positions than that reports 2^CW-1 instead of wrapping.
- R4: For each position with a nonzero label, exactly one broadcast command (`cmdOp` = 2) is issued. Its `cmdKey` is that position's label and its `cmdData` is the count read from that position plus one.
- R5: Positions with label 0 produce no broadcast command, and their plane-A words remain 0 after the scan.
- R6: `done` is high for exactly one cycle. If `start` is sampled at clock edge E0, `done` is high during the cycle that follows edge E0+3N.
- R7: `start` asserted while a scan is in progress is ignored. The scan timing, the number of reads and the final areas are unchanged.
- R8: After the scan, the plane-A word of every nonzero-labeled position equals the number of positions that carry the same label, limited as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| done | output | 1 | One-cycle pulse after the last position |
| cmdOp | output | 2 | Memory command: 0 none, 1 read pair, 2 associative broadcast |
| cmdAddr | output | AW | Position to read |
| cmdKey | output | LW | Label to match in plane B for a broadcast |
| cmdData | output | CW | Count written to matching plane-A words |
| rdLabel | input | LW | Plane-B label of the position read, valid the cycle after the read |
| rdCount | input | CW | Plane-A count of the position read, valid the cycle after the read |

## Verification
A new start request can coincide with a scan step already in progress, both in the middle of the scan and in the final broadcast cycle, where a careless controller would restart or extend the run. The bench provokes this by pulsing `start` during those cycles of some scans. It judges the result by the done pulse still arriving exactly 3N+1 cycles after the original request, by exactly N reads being logged, and by the areas not being inflated. A second instance with a 2-bit count word drives saturation, where the read-increment path meets a count that is already at its maximum.

// File: rtl/area_acc_pkg.sv
package area_acc_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_BCAST = 2'd2
  } memOp_e;

  typedef struct packed {
    logic issueRead;
    logic captureVal;
    logic issueWrite;
  } stepStrobe_t;

endpackage

// File: rtl/area_ctrl.sv
module area_ctrl
  import area_acc_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output stepStrobe_t   strobe,
  output logic [AW-1:0] pos,
  output logic          done
);

  localparam logic [AW-1:0] LAST_POS = AW'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_INC, S_WRITE} phase_e;
  phase_e phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= S_IDLE;
      pos   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        S_IDLE: begin
          if (start) begin
            phase <= S_READ;
            pos   <= '0;
          end
        end
        S_READ: phase <= S_INC;
        S_INC:  phase <= S_WRITE;
        S_WRITE: begin
          if (pos == LAST_POS) begin
            phase <= S_IDLE;
            done  <= 1'b1;
          end else begin
            pos   <= pos + 1'b1;
            phase <= S_READ;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.issueRead  = (phase == S_READ);
    strobe.captureVal = (phase == S_INC);
    strobe.issueWrite = (phase == S_WRITE);
  end

  // R6: done never lasts two cycles
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an accepted start leads to a read of position 0
  p_start_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_IDLE && start) |=> (strobe.issueRead && pos == '0));

  // R7: a start during a scan does not move the position back
  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_INC && start) |=> (strobe.issueWrite && $stable(pos)));

  // R2: read, capture and write follow each other
  p_phase_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueRead |=> strobe.captureVal);

endmodule

// File: rtl/area_datapath.sv
module area_datapath
  import area_acc_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  stepStrobe_t   strobe,
  input  logic [AW-1:0] pos,
  input  logic [LW-1:0] rdLabel,
  input  logic [CW-1:0] rdCount,
  output logic [1:0]    cmdOp,
  output logic [AW-1:0] cmdAddr,
  output logic [LW-1:0] cmdKey,
  output logic [CW-1:0] cmdData
);

  localparam logic [CW-1:0] COUNT_MAX = {CW{1'b1}};

  logic [LW-1:0] labelReg;
  logic [CW-1:0] countReg;
  logic [CW-1:0] countNext;

  assign countNext = (rdCount == COUNT_MAX) ? COUNT_MAX : rdCount + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      labelReg <= '0;
      countReg <= '0;
    end else if (strobe.captureVal) begin
      labelReg <= rdLabel;
      countReg <= countNext;
    end
  end

  always_comb begin
    cmdOp   = OP_NOP;
    cmdAddr = pos;
    cmdKey  = labelReg;
    cmdData = countReg;
    if (strobe.issueRead)
      cmdOp = OP_READ;
    else if (strobe.issueWrite && labelReg != '0)
      cmdOp = OP_BCAST;
  end

  // R3: a full count stays full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureVal && rdCount == COUNT_MAX) |=> (countReg == COUNT_MAX));

  // R4: a non-full count is raised by exactly one
  p_increment_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureVal && rdCount != COUNT_MAX) |=> (countReg == $past(rdCount) + 1'b1));

  // R5: background is never broadcast
  p_no_bg_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == OP_BCAST) |-> (cmdKey != '0));

  // R4: a broadcast carries the label captured the cycle before
  p_key_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureVal && rdLabel != '0) |=> (cmdOp == OP_BCAST && cmdKey == $past(rdLabel)));

endmodule

// File: rtl/region_area_acc.sv
module region_area_acc
  import area_acc_pkg::*;
#(
  parameter int N  = 16,
  parameter int LW = 4,
  parameter int CW = 5,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          done,
  output logic [1:0]    cmdOp,
  output logic [AW-1:0] cmdAddr,
  output logic [LW-1:0] cmdKey,
  output logic [CW-1:0] cmdData,
  input  logic [LW-1:0] rdLabel,
  input  logic [CW-1:0] rdCount
);

  stepStrobe_t   strobe;
  logic [AW-1:0] pos;

  area_ctrl #(.N(N), .AW(AW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .pos    (pos),
    .done   (done)
  );

  area_datapath #(.AW(AW), .LW(LW), .CW(CW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pos     (pos),
    .rdLabel (rdLabel),
    .rdCount (rdCount),
    .cmdOp   (cmdOp),
    .cmdAddr (cmdAddr),
    .cmdKey  (cmdKey),
    .cmdData (cmdData)
  );

  // R1: no command while the scan is not running after reset
  p_quiet_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cmdOp == 2'd0));

endmodule

// File: tb/region_area_acc_bench.sv
module area_mem_model #(
  parameter int N  = 16,
  parameter int LW = 4,
  parameter int CW = 5,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic [1:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [LW-1:0] cmdKey,
  input  logic [CW-1:0] cmdData,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic [LW-1:0] loadLabel,
  output logic [LW-1:0] rdLabel,
  output logic [CW-1:0] rdCount
);
  logic [LW-1:0] planeB [N];
  logic [CW-1:0] planeA [N];

  initial begin
    rdLabel = '0;
    rdCount = '0;
  end

  always @(posedge clk) begin
    if (loadEn) begin
      planeB[loadAddr] <= loadLabel;
      planeA[loadAddr] <= '0;
    end
    if (cmdOp == 2'd1) begin
      rdLabel <= planeB[cmdAddr];
      rdCount <= planeA[cmdAddr];
    end
    if (cmdOp == 2'd2) begin
      for (int j = 0; j < N; j++)
        if (planeB[j] == cmdKey) planeA[j] <= cmdData;
    end
  end
endmodule

module region_area_acc_bench;
  localparam int N  = 16;
  localparam int LW = 4;
  localparam int CW = 5;
  localparam int SCW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic done0, done1;
  logic [1:0] op0, op1;
  logic [AW-1:0] addr0, addr1;
  logic [LW-1:0] key0, key1;
  logic [CW-1:0] data0;
  logic [SCW-1:0] data1;
  logic [LW-1:0] rl0, rl1;
  logic [CW-1:0] rc0;
  logic [SCW-1:0] rc1;
  logic loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [LW-1:0] loadLabel = '0;

  always #2.5 clk = ~clk;

  region_area_acc #(.N(N), .LW(LW), .CW(CW)) u_region_area_acc (
    .clk(clk), .rstN(rstN), .start(start0), .done(done0), .cmdOp(op0),
    .cmdAddr(addr0), .cmdKey(key0), .cmdData(data0), .rdLabel(rl0), .rdCount(rc0));

  region_area_acc #(.N(N), .LW(LW), .CW(SCW)) u_region_area_acc_sat (
    .clk(clk), .rstN(rstN), .start(start1), .done(done1), .cmdOp(op1),
    .cmdAddr(addr1), .cmdKey(key1), .cmdData(data1), .rdLabel(rl1), .rdCount(rc1));

  area_mem_model #(.N(N), .LW(LW), .CW(CW), .AW(AW)) mdl0 (
    .clk(clk), .cmdOp(op0), .cmdAddr(addr0), .cmdKey(key0), .cmdData(data0),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadLabel(loadLabel), .rdLabel(rl0), .rdCount(rc0));

  area_mem_model #(.N(N), .LW(LW), .CW(SCW), .AW(AW)) mdl1 (
    .clk(clk), .cmdOp(op1), .cmdAddr(addr1), .cmdKey(key1), .cmdData(data1),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadLabel(loadLabel), .rdLabel(rl1), .rdCount(rc1));

  int checks = 0;
  int fails = 0;
  int cycleCount = 0;
  logic [LW-1:0] labArr [N];

  // monitor of the main instance's command port
  int readLog [N];
  int readCnt = 0;
  int bcastCnt = 0;
  int bcastBad = 0;
  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (rstN && op0 == 2'd1) begin
      if (readCnt < N) readLog[readCnt] = int'(addr0);
      readCnt = readCnt + 1;
    end
    if (rstN && op0 == 2'd2) begin
      bcastCnt = bcastCnt + 1;
      if (key0 == '0) bcastBad = bcastBad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int areaOf(input logic [LW-1:0] lab, input int maxv);
    int c = 0;
    for (int j = 0; j < N; j++) if (labArr[j] == lab) c++;
    return (c > maxv) ? maxv : c;
  endfunction

  task automatic loadRow();
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      loadEn = 1'b1;
      loadAddr = AW'(j);
      loadLabel = labArr[j];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runScan(input int sel, input bit midStart);
    int cyc = 0;
    bit seen = 0;
    @(negedge clk);
    readCnt = 0; bcastCnt = 0; bcastBad = 0;
    if (sel == 0) start0 = 1'b1; else start1 = 1'b1;
    @(posedge clk);
    #1;
    start0 = 1'b0; start1 = 1'b0;
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (sel == 0) start0 = midStart && (cyc == 10 || cyc == 3*N);
      if ((sel == 0 && done0) || (sel == 1 && done1)) begin seen = 1; break; end
    end
    start0 = 1'b0;
    chk(seen && cyc == 3*N + 1, sel == 0 ? (midStart ? "R7 timing" : "R6 done cycle") : "R6 sat done cycle",
        cyc, 3*N + 1);
    @(negedge clk);
    chk((sel == 0) ? !done0 : !done1, "R6 one-cycle pulse", int'((sel == 0) ? done0 : done1), 0);
  endtask

  task automatic scanMain(input bit midStart);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    int nz = 0;
    bit ordered = 1;
    int zeroBad = 0;
    runScan(0, midStart);
    for (int j = 0; j < N; j++) begin
      int e = (labArr[j] == '0) ? 0 : areaOf(labArr[j], (1 << CW) - 1);
      if (labArr[j] != '0) nz++;
      if (labArr[j] == '0 && mdl0.planeA[j] != '0) zeroBad++;
      if (int'(mdl0.planeA[j]) != e) begin
        if (bad == 0) begin firstAct = int'(mdl0.planeA[j]); firstExp = e; end
        bad++;
      end
    end
    for (int j = 0; j < N && j < readCnt; j++) if (readLog[j] != j) ordered = 0;
    chk(bad == 0, midStart ? "R7 areas" : "R8 areas", firstAct, firstExp);
    chk(zeroBad == 0 && bcastBad == 0, "R5 background untouched", zeroBad + bcastBad, 0);
    chk(readCnt == N && ordered, "R2 read order", readCnt, N);
    chk(bcastCnt == nz, "R4 one broadcast per labeled position", bcastCnt, nz);
  endtask

  task automatic scanSat();
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    runScan(1, 1'b0);
    for (int j = 0; j < N; j++) begin
      int e = (labArr[j] == '0) ? 0 : areaOf(labArr[j], (1 << SCW) - 1);
      if (int'(mdl1.planeA[j]) != e) begin
        if (bad == 0) begin firstAct = int'(mdl1.planeA[j]); firstExp = e; end
        bad++;
      end
    end
    chk(bad == 0, "R3 saturated areas", firstAct, firstExp);
  endtask

  task automatic trial(input bit midStart);
    loadRow();
    scanMain(midStart);
    scanSat();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done0 == 1'b0 && op0 == 2'd0, "R1 reset state", int'(op0), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(done0 == 1'b0 && op0 == 2'd0 && op1 == 2'd0, "R1 idle after reset", int'(op0), 0);

    // directed: all background
    for (int j = 0; j < N; j++) labArr[j] = '0;
    trial(1'b0);
    // directed: one region over the whole row (saturates the narrow count)
    for (int j = 0; j < N; j++) labArr[j] = 4'd5;
    trial(1'b0);
    // directed: all distinct labels
    for (int j = 0; j < N; j++) labArr[j] = LW'(j);
    trial(1'b0);
    // directed: busy start pulses
    for (int j = 0; j < N; j++) labArr[j] = LW'(j % 3);
    trial(1'b1);
    // random rows, dense and sparse label sets
    for (int t = 0; t < 12; t++) begin
      for (int j = 0; j < N; j++)
        labArr[j] = (t % 2 == 0) ? LW'($urandom_range(0, 3)) : LW'($urandom_range(0, 15));
      trial(t % 4 == 3);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycleCount > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycleCount, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule